// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It is built as a chain of identical one-bit cells, and one cell serves each bit of the operand width. Each cell receives one bit of each operand, the carry from the cell below it, a shared invert control and a shared operation code. From these it forms one result bit and the carry it passes upward. The unit supports bitwise AND, bitwise OR, addition and two's-complement subtraction.

Subtraction reuses the adder. A single invert line flips every bit of `b_i` and also feeds the carry into the least significant cell, so the chain computes a + ~b + 1. The carry out of the top cell and a signed overflow flag are reported for the arithmetic operation only.

Top module: `bitslice_alu`

## Requirements
- R1: With op_i = 2'b00 and b_inv_i = 0, result_o equals a_i AND b_i.
- R2: With op_i = 2'b01 and b_inv_i = 0, result_o equals a_i OR b_i.
- R3: With op_i = 2'b10 and b_inv_i = 0, result_o equals (a_i + b_i) modulo 2^W, and carry_o is the carry out of bit W-1. carry_o is therefore the overflow indicator for unsigned addition.
- R4: With op_i = 2'b10 and b_inv_i = 1, result_o equals (a_i - b_i) modulo 2^W, and carry_o equals the carry out of a_i + ~b_i + 1. That carry is 1 exactly when a_i >= b_i as unsigned values.
- R5: For addition, overflow_o is 1 exactly when the signed sum of a_i and b_i lies outside the range -2^(W-1) to 2^(W-1)-1. One example at W=4 is 7+4; another is (-4)+(-6).
- R6: For subtraction, overflow_o is 1 exactly when the signed difference a_i - b_i lies outside the same range.
- R7: For op_i = 2'b00, 2'b01 and 2'b11, carry_o and overflow_o are 0.
- R8: With op_i = 2'b11, result_o is all zeros, whatever the operands and b_inv_i are.
- R9: b_inv_i also applies to the logic operations. op_i = 2'b00 gives a_i AND ~b_i, and op_i = 2'b01 gives a_i OR ~b_i.
- R10: For addition, an operand pair whose sign bits differ never sets overflow_o. For subtraction, a pair whose sign bits match never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand, inverted when b_inv_i is set |
| op_i | input | 2 | 00 AND, 01 OR, 10 add/subtract, 11 zero |
| b_inv_i | input | 1 | Inverts b_i and sets the carry into bit 0 |
| result_o | output | W | Operation result |
| carry_o | output | 1 | Carry out of the top bit (arithmetic only) |
| overflow_o | output | 1 | Signed overflow (arithmetic only) |

## Verification
The bench builds two copies of the unit side by side. One uses W=32, the default. The other uses W=4, where all operand pairs, codes and invert settings can be applied in full, so every overflow boundary is reached, including 7+4 and (-4)+(-6). The 32-bit copy receives directed extremes, such as the most negative value minus one, all-ones plus one and zero minus zero, followed by random vectors. Both copies are compared against an integer reference model in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_ARITH = 2'b10,
    OP_ZERO = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    cin_i,
  input  logic    b_inv_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    cout_o
);
  logic b_eff, prop, gen, sum;

  // xor acts as a programmable inverter
  assign b_eff  = b_i ^ b_inv_i;
  assign prop   = a_i ^ b_eff;
  assign gen    = a_i & b_eff;
  assign sum    = prop ^ cin_i;
  assign cout_o = gen | (prop & cin_i);

  always_comb begin
    unique case (op_i)
      OP_AND:   res_o = a_i & b_eff;
      OP_OR:    res_o = a_i | b_eff;
      OP_ARITH: res_o = sum;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    c_into_msb_i,
  input  logic    c_out_msb_i,
  output logic    carry_o,
  output logic    overflow_o
);
  logic arith;
  assign arith      = (op_i == OP_ARITH);
  assign carry_o    = arith & c_out_msb_i;
  assign overflow_o = arith & (c_into_msb_i ^ c_out_msb_i);
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         b_inv_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         overflow_o
);
  localparam int MSB = W - 1;

  alu_op_e    op;
  logic [W:0] carry_c;

  assign op         = alu_op_e'(op_i);
  assign carry_c[0] = b_inv_i;

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .cin_i  (carry_c[i]),
      .b_inv_i(b_inv_i),
      .op_i   (op),
      .res_o  (result_o[i]),
      .cout_o (carry_c[i+1])
    );
  end

  alu_flags u_flags (
    .op_i        (op),
    .c_into_msb_i(carry_c[MSB]),
    .c_out_msb_i (carry_c[W]),
    .carry_o     (carry_o),
    .overflow_o  (overflow_o)
  );
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op_i,
  input logic         b_inv_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         overflow_o,
  input logic [W:0]   carry_c
);
  logic         arith;
  logic [W-1:0] b_eff;
  assign arith = (op_i == 2'b10);
  assign b_eff = b_inv_i ? ~b_i : b_i;

  always_comb begin
    // R5 / R6: flag matches sign rule on operands vs result
    p_sign_rule_r5: assert (!arith || (overflow_o ==
        ((a_i[W-1] == b_eff[W-1]) && (result_o[W-1] != a_i[W-1]))))
      else $error("overflow sign rule");
    // R10
    p_no_overflow_r10: assert (!(arith && (a_i[W-1] != b_eff[W-1])) || !overflow_o)
      else $error("overflow on mixed signs");
    // R3 / R4: carry out follows the chain
    p_carry_r3: assert (!arith || (carry_o == carry_c[W]))
      else $error("carry mismatch");
    // R7
    p_flags_idle_r7: assert (arith || (!carry_o && !overflow_o))
      else $error("flags set in logic op");
    // R8
    p_zero_op_r8: assert ((op_i != 2'b11) || (result_o == '0))
      else $error("zero op nonzero");
    // R4: subtraction injects carry into bit 0
    p_sub_cin_r4: assert (carry_c[0] == b_inv_i)
      else $error("carry-in not tied to invert");
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .op_i      (op_i),
  .b_inv_i   (b_inv_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .overflow_o(overflow_o),
  .carry_c   (carry_c)
);

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [1:0]  op32;
  logic        inv32, c32, v32;
  logic [3:0]  a4, b4, r4;
  logic [1:0]  op4;
  logic        inv4, c4, v4;

  bitslice_alu #(.W(32)) dut (
    .a_i(a32), .b_i(b32), .op_i(op32), .b_inv_i(inv32),
    .result_o(r32), .carry_o(c32), .overflow_o(v32));

  bitslice_alu #(.W(4)) dut4 (
    .a_i(a4), .b_i(b4), .op_i(op4), .b_inv_i(inv4),
    .result_o(r4), .carry_o(c4), .overflow_o(v4));

  function automatic void ref_model(input int w, input longint a, input longint b,
                                    input int op, input bit inv,
                                    output longint res, output bit c, output bit v);
    longint mask, be, s, sa, sb, sr, lo, hi;
    mask = (longint'(1) << w) - 1;
    be = inv ? (~b & mask) : b;
    c = 1'b0; v = 1'b0;
    case (op)
      0: res = a & be;
      1: res = a | be;
      2: begin
        s = a + be + (inv ? 1 : 0);
        res = s & mask;
        c = s[w];
        sa = a[w-1] ? a - (mask + 1) : a;
        sb = b[w-1] ? b - (mask + 1) : b;
        sr = inv ? sa - sb : sa + sb;
        lo = -(longint'(1) << (w - 1));
        hi = (longint'(1) << (w - 1)) - 1;
        v = (sr < lo) || (sr > hi);
      end
      default: res = 0;
    endcase
  endfunction

  function automatic string res_tag(int op, bit inv);
    case (op)
      0: return inv ? "R9" : "R1";
      1: return inv ? "R9" : "R2";
      2: return inv ? "R4" : "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run32(logic [31:0] a, logic [31:0] b, int op, bit inv);
    longint er; bit ec, ev;
    @(negedge clk);
    a32 = a; b32 = b; op32 = 2'(op); inv32 = inv;
    @(posedge clk);
    ref_model(32, longint'(a), longint'(b), op, inv, er, ec, ev);
    cmp(res_tag(op, inv), "result32", longint'(r32), er);
    cmp(op == 2 ? (inv ? "R4" : "R3") : "R7", "carry32", longint'(c32), longint'(ec));
    cmp(op == 2 ? (inv ? "R6" : "R5") : "R7", "ovf32", longint'(v32), longint'(ev));
  endtask

  task automatic run4(logic [3:0] a, logic [3:0] b, int op, bit inv);
    longint er; bit ec, ev;
    @(negedge clk);
    a4 = a; b4 = b; op4 = 2'(op); inv4 = inv;
    @(posedge clk);
    ref_model(4, longint'(a), longint'(b), op, inv, er, ec, ev);
    cmp(res_tag(op, inv), "result4", longint'(r4), er);
    cmp(op == 2 ? (inv ? "R4" : "R3") : "R7", "carry4", longint'(c4), longint'(ec));
    // R10 is covered here: mixed-sign pairs expect no overflow
    cmp(op == 2 ? (inv ? "R6" : "R5") : "R7", "ovf4", longint'(v4), longint'(ev));
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a32 = '0; b32 = '0; op32 = 2'b00; inv32 = 1'b0;
    a4 = '0; b4 = '0; op4 = 2'b00; inv4 = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    cmp("R1", "idle result", longint'(r32), 0);
    cmp("R7", "idle flags", longint'({c32, v32}), 0);

    // R5 directed: 7+4 and -4+-6 at W=4
    run4(4'd7, 4'd4, 2, 1'b0);
    run4(4'hC, 4'hA, 2, 1'b0);
    // R10: opposite signs
    run4(4'd7, 4'h8, 2, 1'b0);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int op = 0; op < 4; op++)
          for (int inv = 0; inv < 2; inv++)
            run4(4'(a), 4'(b), op, bit'(inv));

    // full-range extremes at W=32
    run32(32'h7FFF_FFFF, 32'h1, 2, 1'b0);        // R5
    run32(32'h8000_0000, 32'h8000_0000, 2, 1'b0); // R5
    run32(32'hFFFF_FFFF, 32'h1, 2, 1'b0);        // R3 unsigned carry
    run32(32'h8000_0000, 32'h1, 2, 1'b1);        // R6
    run32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2, 1'b1); // R6
    run32(32'h0, 32'h0, 2, 1'b1);                // R4 carry=1
    run32(32'h0, 32'h1, 2, 1'b1);                // R4 borrow
    run32(32'hDEAD_BEEF, 32'h1234_5678, 3, 1'b1); // R8
    run32(32'hF0F0_F0F0, 32'hFF00_FF00, 0, 1'b1); // R9
    run32(32'hF0F0_F0F0, 32'hFF00_FF00, 1, 1'b1); // R9

    for (int i = 0; i < 1500; i++)
      run32($urandom, $urandom, int'($urandom % 4), bit'($urandom % 2));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule